// File: doc/BRIEF.md
# System Control Port with Timer Status Feedback

This block is an 8-bit control and status port placed between the host bus and two timer channel outputs. A host write stores the low control bits. Bit 0 drives the gate input of timer channel 2. Bit 1 enables the speaker path, so that the speaker signal is the channel 2 output ANDed with that bit.

A host read returns the stored control bits together with two status bits taken from the timers. Channel 1 normally runs as a rate generator and emits pulses only one clock wide. Polling software cannot catch pulses that short, so status bit 4 is a flip-flop that changes state on each rising edge of the channel 1 output. Each level then lasts a full timer period, and software can count until the bit sets and then until it clears. Status bit 5 is the live level of the channel 2 output, with no toggling.

All inputs are synchronous to the system clock. A write is taken on a clock edge where `wr_en` is high. A read captures the port value into `rd_data` on a clock edge where `rd_en` is high, and `rd_data` holds that value until the next read.

Top module: `sysctl_port`

## Requirements
- R1: After reset, `gate2` is 0, `spk_out` is 0, the bit 4 toggle is 0 and `rd_data` is 0x00.
- R2: A write sets `gate2` to bit 0 of the written byte from the cycle after the write edge. It keeps that value until the next write.
- R3: `spk_out` equals `tmr_out2` ANDed with the stored bit 1, with no added register delay on `tmr_out2`.
- R4: Bit 4 of the read value inverts exactly once for each rising edge of `tmr_out1`. This holds for a one-cycle pulse and for a level that stays high for many cycles.
- R5: Bit 4 keeps its value between rising edges of `tmr_out1`. Host writes leave bits 4 and 5 of the read value unaffected, even when the written byte has bits 4 and 5 set.
- R6: Bits 3 to 0 of the read value equal bits 3 to 0 of the last written byte.
- R7: Bit 5 of the read value is the level of `tmr_out2` on the read edge.
- R8: Bits 7 and 6 of the read value are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| tmr_out1 | input | 1 | Timer channel 1 output |
| tmr_out2 | input | 1 | Timer channel 2 output |
| rd_data | output | 8 | Port value captured on the last read |
| gate2 | output | 1 | Gate input to timer channel 2 |
| spk_out | output | 1 | Speaker signal, gated channel 2 output |

## Verification
The bench drives one-cycle pulses on channel 1 and also a level held high for several cycles. A design that copied the raw level, or that toggled on every high cycle, would show the wrong parity in bit 4. A long pulse train then checks that bit 4 ends with the parity of the edge count. The bench also writes bytes with bits 4, 5, 6 and 7 set, at times when the toggle is both 0 and 1. A design that stored those bits would return a corrupted status or non-zero upper bits. Finally, the speaker gate is checked with channel 2 high and the enable both on and off, to catch a missing AND or a swapped control bit.

// File: rtl/sysctl_pkg.sv
// Package: shared widths and bit positions of the system control port.
// Assumes an 8-bit host data path. The positions below are fixed by software.
package sysctl_pkg;
    localparam int DATA_W    = 8;
    localparam int CTRL_W    = 4;
    localparam int BIT_GATE  = 0;
    localparam int BIT_SPKEN = 1;
    localparam int BIT_TOG1  = 4;
    localparam int BIT_LIVE2 = 5;
endpackage

// File: rtl/sysctl_ctrl_reg.sv
// Module: stores the low control bits written by the host.
// Assumes wr_en is a single-cycle strobe synchronous to clk.
module sysctl_ctrl_reg
    import sysctl_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [CW-1:0] ctrl_q
);
    // Capture the low control field on each host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data[CW-1:0];
    end

    // R2 / R6: the stored field follows the written byte one cycle later.
    a_r6_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_q == $past(wr_data[CW-1:0]));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/sysctl_edge_toggle.sv
// Module: turns rising edges of a timer output into a level that flips once per edge.
// Assumes tmr_in is synchronous to clk. A registered copy from the previous
// cycle forms the edge detector, and reset clears both flops.
module sysctl_edge_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_in,
    output logic tog_q
);
    logic prev_q;
    logic rise;

    // Find a rising edge by comparing the input with last cycle's copy.
    always_comb rise = tmr_in & ~prev_q;

    // Keep last cycle's input level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= tmr_in;
    end

    // Invert the status level on each detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    tog_q <= 1'b0;
        else if (rise) tog_q <= ~tog_q;
    end

    // R4: an input edge inverts the level exactly once.
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_in && !prev_q) |=> tog_q != $past(tog_q));
    // R5: with no edge, the level holds (this covers a long high phase too).
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_in && !prev_q) |=> $stable(tog_q));
endmodule

// File: rtl/sysctl_read_reg.sv
// Module: assembles the port value and captures it on a host read.
// Assumes rd_en is synchronous to clk. Unused upper bits read as zero.
module sysctl_read_reg
    import sysctl_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [CW-1:0] ctrl_q,
    input  logic          tog1,
    input  logic          live2,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] port_val;

    // Combine the stored controls and the two timer status bits.
    always_comb begin
        port_val            = '0;
        port_val[CW-1:0]    = ctrl_q;
        port_val[BIT_TOG1]  = tog1;
        port_val[BIT_LIVE2] = live2;
    end

    // Capture the port value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= port_val;
    end

    // R7: bit 5 reflects the timer 2 level on the read edge.
    a_r7_live: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data[BIT_LIVE2] == $past(live2));
    // R8: upper bits are never set.
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[W-1:BIT_LIVE2+1] == '0);
endmodule

// File: rtl/sysctl_port.sv
// Module: top of the system control port with timer feedback.
// Assumes all inputs are synchronous to clk. The speaker gate is
// combinational on tmr_out2, so it adds no delay to the audio path.
module sysctl_port
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              tmr_out1,
    input  logic              tmr_out2,
    output logic [DATA_W-1:0] rd_data,
    output logic              gate2,
    output logic              spk_out
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              tog1;

    sysctl_ctrl_reg #(.W(DATA_W), .CW(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
    );

    sysctl_edge_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .tmr_in(tmr_out1), .tog_q(tog1)
    );

    sysctl_read_reg #(.W(DATA_W), .CW(CTRL_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ctrl_q(ctrl_q),
        .tog1(tog1), .live2(tmr_out2), .rd_data(rd_data)
    );

    // Drive the timer 2 gate and the speaker signal from the stored controls.
    always_comb begin
        gate2   = ctrl_q[BIT_GATE];
        spk_out = tmr_out2 & ctrl_q[BIT_SPKEN];
    end

    // R3: the speaker is never active while timer 2 is low.
    a_r3_spk_needs_out2: assert property (@(posedge clk) disable iff (!rst_n)
        spk_out |-> tmr_out2);
    // R2: the gate follows bit 0 of the last write.
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> gate2 == $past(wr_data[BIT_GATE]));
endmodule

// File: tb/test_sysctl_port.sv
// Bench: directed scenarios for the system control port.
module test_sysctl_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       tmr_out1 = 1'b0;
    logic       tmr_out2 = 1'b0;
    logic [7:0] rd_data;
    logic       gate2;
    logic       spk_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sysctl_port i_sysctl_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .tmr_out1(tmr_out1), .tmr_out2(tmr_out2),
        .rd_data(rd_data), .gate2(gate2), .spk_out(spk_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    task automatic pulse1(input int hi_cycles);
        @(negedge clk); tmr_out1 = 1'b1;
        for (int i = 0; i < hi_cycles; i++) @(negedge clk);
        tmr_out1 = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 gate2", {7'd0, gate2}, 8'h00);
        check("R1 spk_out", {7'd0, spk_out}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        do_read(v);
        check("R1 read", v, 8'h00);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        do_write(8'h0F);
        check("R2 gate2 set", {7'd0, gate2}, 8'h01);
        do_read(v);
        check("R6 low nibble", v, 8'h0F);
        do_write(8'hFA);
        check("R2 gate2 clear", {7'd0, gate2}, 8'h00);
        do_read(v);
        check("R8 R5 upper bits after write of FA", v, 8'h0A);
    endtask

    task automatic t_speaker;
        do_write(8'h02);
        @(negedge clk); tmr_out2 = 1'b1; #1;
        check("R3 spk on", {7'd0, spk_out}, 8'h01);
        tmr_out2 = 1'b0; #1;
        check("R3 spk follows out2 low", {7'd0, spk_out}, 8'h00);
        tmr_out2 = 1'b1;
        do_write(8'h01); #1;
        check("R3 spk disabled", {7'd0, spk_out}, 8'h00);
        tmr_out2 = 1'b0;
    endtask

    task automatic t_toggle;
        logic [7:0] v;
        do_write(8'h00);
        pulse1(1);
        do_read(v);
        check("R4 first pulse", v & 8'h10, 8'h10);
        repeat (5) @(negedge clk);
        do_read(v);
        check("R5 hold between edges", v & 8'h10, 8'h10);
        pulse1(1);
        do_read(v);
        check("R4 second pulse", v & 8'h10, 8'h00);
        pulse1(6);
        do_read(v);
        check("R4 long high flips once", v & 8'h10, 8'h10);
        do_write(8'h30);
        do_read(v);
        check("R5 write keeps toggle", v, 8'h10);
        do_write(8'hEF);
        do_read(v);
        check("R5 R6 R8 write EF", v, 8'h1F);
    endtask

    task automatic t_live2;
        logic [7:0] v;
        do_write(8'h00);
        @(negedge clk); tmr_out2 = 1'b1;
        do_read(v);
        check("R7 out2 high", v & 8'h20, 8'h20);
        tmr_out2 = 1'b0;
        do_read(v);
        check("R7 out2 low", v & 8'h20, 8'h00);
    endtask

    task automatic t_train;
        logic [7:0] v;
        // Toggle is 1 here; 7 more edges give parity 0.
        for (int k = 0; k < 7; k++) begin
            pulse1(1 + (k % 3));
            @(negedge clk);
        end
        do_read(v);
        check("R4 pulse train parity", v & 8'h10, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ctrl;
        t_speaker;
        t_toggle;
        t_live2;
        t_train;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule